// File: doc/BRIEF.md
# Prescaled SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the module clock. The overall divide is the product of two programmable factors. A two-bit prescaler index selects a small odd-or-even divide of 2, 3, 5 or 7. A four-bit scaler index selects from a table that grows linearly at first and then doubles. The prescaler runs as a clock-enable divider, and the scaler counts those enables over one half of the serial clock period, so high and low times are always equal. This holds even when the prescaler is odd.

Besides the clock pin, the block drives two single-cycle strobes for the shift engine. One marks the edge on which received data is captured. The other marks the edge on which transmit data moves on. The clock-phase input decides which edge plays which role. A frame-length input sets how many serial clock cycles make one frame. A one-cycle pulse follows the final edge of each frame, and frames repeat back to back for as long as the enable stays high. All pins are plain control and status signals; no data stream crosses this block, so no valid/ready handshake is used.

Top module: `spi_baud_gen`

## Requirements
- R1: Prescaler index `pre_idx` values 0, 1, 2, 3 give a prescale factor P of 2, 3, 5, 7 respectively.
- R2: Scaler index `scl_idx` values 0 to 3 give a scaler factor S of 2, 4, 6, 8. Values 4 to 15 give S = 2^(idx), so index 4 gives 16 and index 15 gives 32768.
- R3: While enabled, `sck` toggles every T = P*S/2 module clock cycles. Edge j of the run becomes visible right after the (j*T)-th rising clock edge at which `en` was high, which makes both halves of the period exactly T cycles long.
- R4: While `en` is low, `sck` equals the `cpol` input in the same cycle, with no clock edge needed. The strobes and `frame_done` are low. Dropping `en` restarts both counters, so the first edge after the next enable again comes T cycles later.
- R5: With `cpha` = 0, `sample_stb` is high for exactly the one cycle in which a leading edge (odd-numbered edge, leaving idle) first shows on `sck`. `shift_stb` does the same for trailing edges (even-numbered, returning to idle). The two strobes are never high together.
- R6: With `cpha` = 1 the roles swap: `shift_stb` marks leading edges and `sample_stb` marks trailing edges.
- R7: A frame is N = `frame_len`+1 serial clock cycles long. `frame_done` is high for one cycle, one cycle after the 2N-th edge shows. The next frame starts without a gap, and its first edge comes T cycles after the previous edge.
- R8: `pre_idx`, `scl_idx`, `cpol`, `cpha` and `frame_len` are captured at every rising clock edge at which `en` is low. Changes made while `en` is high have no effect until after the next disable.
- R9: During reset with `en` low, `sck` equals `cpol` and `sample_stb`, `shift_stb` and `frame_done` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces idle and reloads the configuration |
| pre_idx | input | 2 | Prescaler index |
| scl_idx | input | 4 | Scaler index |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Capture on the leading (0) or trailing (1) edge |
| frame_len | input | FRAME_W | Serial clock cycles per frame minus one |
| sck | output | 1 | Serial clock |
| sample_stb | output | 1 | One-cycle strobe on each capture edge |
| shift_stb | output | 1 | One-cycle strobe on each launch edge |
| frame_done | output | 1 | One-cycle pulse after a frame's last edge |

## Verification
Edge j of a run is due in the cycle after the (j*T)-th enabled rising edge, and both strobes are due in that same cycle. `frame_done` is due one cycle after the 2N-th edge. The idle level on disable is due at once, with no clock edge. The bench counts enabled rising edges itself from the cycle it raises `en`, and it samples every output on the following falling edge. It computes the expected `sck` level, strobe pair and done pulse from that count and T. For the disable case it checks a moment after changing `en`, before any rising edge.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;

  localparam int PRE_IDX_W = 2;
  localparam int SCL_IDX_W = 4;
  localparam int PRE_CNT_W = 3;
  localparam int HALF_W    = 15;
  localparam int LIN_STEPS = 4;

  typedef struct packed {
    logic [PRE_IDX_W-1:0] pre_idx;
    logic [SCL_IDX_W-1:0] scl_idx;
    logic                 cpol;
    logic                 cpha;
  } baud_cfg_t;

  function automatic logic [PRE_CNT_W-1:0] pre_divisor(input logic [PRE_IDX_W-1:0] idx);
    logic [PRE_CNT_W-1:0] d;
    case (idx)
      2'd0:    d = PRE_CNT_W'(2);
      2'd1:    d = PRE_CNT_W'(3);
      2'd2:    d = PRE_CNT_W'(5);
      default: d = PRE_CNT_W'(7);
    endcase
    return d;
  endfunction

  // Half of the scaler factor: linear 1..4 for the low indices, then powers of two.
  function automatic logic [HALF_W-1:0] scl_half(input logic [SCL_IDX_W-1:0] idx);
    logic [HALF_W-1:0] h;
    if (idx < SCL_IDX_W'(LIN_STEPS))
      h = HALF_W'(idx) + HALF_W'(1);
    else
      h = HALF_W'(1) << (idx - SCL_IDX_W'(1));
    return h;
  endfunction

endpackage

// File: rtl/spi_baud_prescale.sv
module spi_baud_prescale #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] div,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  always_comb wrap = (cnt >= div - CNT_W'(1));
  assign tick = en && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (wrap)   cnt <= '0;
    else             cnt <= cnt + CNT_W'(1);
  end

  p_pre_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt < div));

endmodule

// File: rtl/spi_baud_scaler.sv
module spi_baud_scaler #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] half,
  output logic             half_done
);
  logic [CNT_W-1:0] cnt;
  logic             at_end;

  always_comb at_end = (cnt >= half - CNT_W'(1));
  assign half_done = tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!en)      cnt <= '0;
    else if (tick) begin
      if (at_end)      cnt <= '0;
      else             cnt <= cnt + CNT_W'(1);
    end
  end

  p_scl_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt < half));

  p_tick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(tick)) |-> $stable(cnt));

endmodule

// File: rtl/spi_baud_edge_seq.sv
module spi_baud_edge_seq #(
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               half_done,
  input  logic               cpha,
  input  logic [FRAME_W-1:0] frame_len,
  output logic               phase,
  output logic               sample_q,
  output logic               shift_q,
  output logic               done_q
);
  logic [FRAME_W-1:0] cyc_cnt;
  logic               last_q;
  logic               leading;
  logic               last_edge;

  always_comb begin
    leading   = !phase;
    last_edge = half_done && phase && (cyc_cnt == frame_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= 1'b0;
      cyc_cnt  <= '0;
      sample_q <= 1'b0;
      shift_q  <= 1'b0;
      last_q   <= 1'b0;
      done_q   <= 1'b0;
    end else if (!en) begin
      phase    <= 1'b0;
      cyc_cnt  <= '0;
      sample_q <= 1'b0;
      shift_q  <= 1'b0;
      last_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      sample_q <= 1'b0;
      shift_q  <= 1'b0;
      if (half_done) begin
        phase    <= !phase;
        sample_q <= leading ^ cpha;
        shift_q  <= !(leading ^ cpha);
        if (phase)
          cyc_cnt <= last_edge ? '0 : cyc_cnt + FRAME_W'(1);
      end
      last_q <= last_edge;
      done_q <= last_q;
    end
  end

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_q && shift_q));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !phase);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_frame_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cyc_cnt <= frame_len));

endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_baud_pkg::*;
#(
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [1:0]         pre_idx,
  input  logic [3:0]         scl_idx,
  input  logic               cpol,
  input  logic               cpha,
  input  logic [FRAME_W-1:0] frame_len,
  output logic               sck,
  output logic               sample_stb,
  output logic               shift_stb,
  output logic               frame_done
);
  baud_cfg_t            cfg_q;
  logic [FRAME_W-1:0]   frame_q;
  logic [PRE_CNT_W-1:0] pre_div;
  logic [HALF_W-1:0]    half;
  logic                 tick;
  logic                 half_done;
  logic                 phase;
  logic                 sample_q;
  logic                 shift_q;
  logic                 done_q;

  // Configuration tracks the inputs while idle and freezes while running.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      frame_q <= '0;
    end else if (!en) begin
      cfg_q.pre_idx <= pre_idx;
      cfg_q.scl_idx <= scl_idx;
      cfg_q.cpol    <= cpol;
      cfg_q.cpha    <= cpha;
      frame_q       <= frame_len;
    end
  end

  always_comb begin
    pre_div = pre_divisor(cfg_q.pre_idx);
    half    = scl_half(cfg_q.scl_idx);
  end

  spi_baud_prescale #(.CNT_W(PRE_CNT_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .div   (pre_div),
    .tick  (tick)
  );

  spi_baud_scaler #(.CNT_W(HALF_W)) u_scl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .tick      (tick),
    .half      (half),
    .half_done (half_done)
  );

  spi_baud_edge_seq #(.FRAME_W(FRAME_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .half_done (half_done),
    .cpha      (cfg_q.cpha),
    .frame_len (frame_q),
    .phase     (phase),
    .sample_q  (sample_q),
    .shift_q   (shift_q),
    .done_q    (done_q)
  );

  assign sck        = en ? (cfg_q.cpol ^ phase) : cpol;
  assign sample_stb = en & sample_q;
  assign shift_stb  = en & shift_q;
  assign frame_done = en & done_q;

  p_edge_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (sck != $past(sck))) |-> (sample_stb || shift_stb));

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> ($stable(cfg_q) && $stable(frame_q)));

  p_done_after_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (sck == cfg_q.cpol));

endmodule

// File: tb/spi_baud_gen_tb.sv
module spi_baud_gen_tb;
  localparam int FW = 4;
  localparam int NV = 8;
  // {pre_idx[2], scl_idx[4], cpol, cpha, frame_len[4], expected T[16]}
  localparam logic [27:0] VEC [NV] = '{
    {2'd0, 4'd0, 1'b0, 1'b0, 4'd7,  16'd2},
    {2'd1, 4'd1, 1'b1, 1'b0, 4'd3,  16'd6},
    {2'd2, 4'd2, 1'b0, 1'b1, 4'd0,  16'd15},
    {2'd3, 4'd3, 1'b1, 1'b1, 4'd2,  16'd28},
    {2'd1, 4'd4, 1'b0, 1'b1, 4'd1,  16'd24},
    {2'd0, 4'd5, 1'b1, 1'b0, 4'd15, 16'd32},
    {2'd2, 4'd6, 1'b0, 1'b0, 4'd0,  16'd160},
    {2'd0, 4'd7, 1'b1, 1'b1, 4'd1,  16'd128}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [1:0]    pre_idx = '0;
  logic [3:0]    scl_idx = '0;
  logic          cpol = 1'b0;
  logic          cpha = 1'b0;
  logic [FW-1:0] frame_len = '0;
  logic          sck, sample_stb, shift_stb, frame_done;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            finished = 1'b0;

  always #10 clk = ~clk;

  spi_baud_gen #(.FRAME_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .pre_idx(pre_idx), .scl_idx(scl_idx),
    .cpol(cpol), .cpha(cpha), .frame_len(frame_len), .sck(sck),
    .sample_stb(sample_stb), .shift_stb(shift_stb), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Expected outputs at enabled cycle c, from the requirements alone.
  task automatic check_cycle(input int c, input int t, input bit pol, input bit ph, input int n);
    int  edges = c / t;
    bit  at_edge = (c % t == 0);
    bit  lead = (edges % 2 == 1);
    bit  e_sck = pol ^ bit'(edges % 2);
    bit  e_smp = at_edge && (lead ? !ph : ph);
    bit  e_shf = at_edge && (lead ? ph : !ph);
    bit  e_done = (c > 1) && ((c - 1) % (2 * n * t) == 0);
    chk(sck == e_sck, "R3", "sck level", sck, e_sck);
    chk(sample_stb == e_smp, ph ? "R6" : "R5", "sample_stb", sample_stb, e_smp);
    chk(shift_stb == e_shf, ph ? "R6" : "R5", "shift_stb", shift_stb, e_shf);
    chk(frame_done == e_done, "R7", "frame_done", frame_done, e_done);
  endtask

  task automatic setup(input logic [1:0] p, input logic [3:0] s, input bit pol, input bit ph, input int f);
    @(negedge clk);
    en = 1'b0; pre_idx = p; scl_idx = s; cpol = pol; cpha = ph; frame_len = FW'(f);
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    // R9 reset state
    cpol = 1'b1;
    repeat (3) @(negedge clk);
    chk(sck == 1'b1, "R9", "sck in reset", sck, 1);
    chk(!sample_stb && !shift_stb, "R9", "strobes in reset", sample_stb | shift_stb, 0);
    chk(!frame_done, "R9", "done in reset", frame_done, 0);
    cpol = 1'b0; #1;
    chk(sck == 1'b0, "R4", "sck follows cpol while idle", sck, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R1 R2 R3 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [27:0] v = VEC[i];
      int t = int'(v[15:0]);
      int n = int'(v[19:16]) + 1;
      setup(v[27:26], v[25:22], v[21], v[20], int'(v[19:16]));
      for (int c = 1; c <= (2 * n + 1) * t + 1; c++) begin
        @(negedge clk);
        check_cycle(c, t, v[21], v[20], n);
      end
      en = 1'b0; #1;
      chk(sck == v[21], "R4", "idle on disable", sck, v[21]);
      chk(!sample_stb && !shift_stb && !frame_done, "R4", "quiet on disable",
          sample_stb | shift_stb | frame_done, 0);
    end

    // R8: changes while enabled ignored (T=2 keeps going)
    setup(2'd0, 4'd0, 1'b0, 1'b0, 15);
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      if (c == 3) begin pre_idx = 2'd3; scl_idx = 4'd5; cpol = 1'b1; cpha = 1'b1; end
      check_cycle(c, 2, 1'b0, 1'b0, 16);
    end
    en = 1'b0; #1;
    chk(sck == 1'b1, "R4", "idle uses live cpol", sck, 1);
    @(negedge clk);
    en = 1'b1;  // now P=7, S=32, T=112, cpol=1
    for (int c = 1; c <= 112; c++) begin
      @(negedge clk);
      if (c == 111) chk(sck == 1'b1, "R8", "new config before edge", sck, 1);
      if (c == 112) begin
        chk(sck == 1'b0, "R8", "new config first edge", sck, 0);
        chk(shift_stb == 1'b1, "R8", "new cpha applied", shift_stb, 1);
      end
    end

    // R4: short disable restarts counters
    setup(2'd1, 4'd1, 1'b0, 1'b0, 3);
    repeat (4) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    for (int c = 1; c <= 6; c++) begin
      @(negedge clk);
      if (c == 5) chk(sck == 1'b0, "R4", "no early edge after restart", sck, 0);
      if (c == 6) chk(sck == 1'b1, "R4", "first edge after restart", sck, 1);
    end

    // R1 R2: larger factors
    setup(2'd3, 4'd9, 1'b0, 1'b0, 0);  // T = 7*512/2 = 1792
    for (int c = 1; c <= 1792; c++) begin
      @(negedge clk);
      if (c == 1791) chk(sck == 1'b0, "R1", "pre=7 scl=512 before edge", sck, 0);
      if (c == 1792) chk(sck == 1'b1 && sample_stb, "R2", "pre=7 scl=512 edge", sck, 1);
    end
    setup(2'd0, 4'd15, 1'b1, 1'b0, 0);  // T = 2*32768/2 = 32768
    for (int c = 1; c <= 32768; c++) begin
      @(negedge clk);
      if (c == 32767) chk(sck == 1'b1, "R2", "max scaler before edge", sck, 1);
      if (c == 32768) chk(sck == 1'b0, "R2", "max scaler edge", sck, 0);
    end
    @(negedge clk);
    en = 1'b0;

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule